// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Aligner

This block sits between a processor core and a byte-addressable, word-organised memory that keeps bytes in big-endian order. On a load it takes the word read from memory, the low address bits, the current value of the destination register and an access kind. It produces the value to write back: a byte or halfword with sign or zero extension, a full word, or a partial word that merges memory bytes with register bytes for unaligned left and right loads. On a store it takes the register value and the low address bits. It produces lane-shifted write data and one write enable per byte lane.

Halfword accesses at an odd address and word accesses at an address that is not word-aligned are flagged as misaligned. A misaligned access writes no register and enables no byte lane. Byte, left and right accesses are never misaligned. All outputs are registered, so a request presented on one clock edge gives its result on the next. Address generation and the memory itself lie outside the block.

Top module: `be_lsu_align`

## Requirements
- R1: Synchronous active-high reset clears ld_valid, ld_data, st_be, st_wdata and misalign to zero on the clock edge where rst is high. This holds even when a request is presented in that cycle.
- R2: Results appear one clock edge after a request with req_valid high. After an edge where req_valid was low, ld_valid, st_be and misalign are all zero.
- R3: Memory byte at address offset k (k = req_addr_lo) is taken from mem_rdata bits 31-8k down to 24-8k. Kind code 0 is a signed byte load and copies the byte's bit 7 into bits 31..8. Kind code 1 is an unsigned byte load and puts zeros in bits 31..8.
- R4: Kind codes 2 (signed) and 3 (unsigned) are halfword loads. The byte at offset k goes to bits 15..8 and the byte at k+1 to bits 7..0. Bits 31..16 are filled with sign copies for code 2 and with zeros for code 3.
- R5: Kind code 4 is a word load and returns mem_rdata unchanged.
- R6: Kind code 5 is the left partial load. At offset 0 the result is the whole word. At offset k > 0, memory bytes k..3 fill the top 4-k register lanes and the low k register bytes of reg_val are kept.
- R7: Kind code 6 is the right partial load. At offset k < 3, memory bytes 0..k fill the low k+1 register lanes and the upper bytes of reg_val are kept. At offset 3 the result is the whole memory word.
- R8: A byte store (kind code 0 or 1, req_is_store = 1) puts reg_val bits 7..0 in the addressed lane. A halfword store puts reg_val bits 15..0 in lanes k and k+1. st_be bit i enables st_wdata bits 8i+7..8i, so offset k maps to st_be bit 3-k. Data in disabled lanes is zero.
- R9: A word store (kind code 4) enables all four lanes with st_wdata equal to reg_val.
- R10: A left partial store (kind code 5) at offset k enables lanes k..3 and writes the top 4-k bytes of reg_val into them, in order.
- R11: A right partial store (kind code 6) at offset k enables lanes 0..k and writes the low k+1 bytes of reg_val into them, ending at lane k.
- R12: A halfword access at an odd offset, or a word access at a nonzero offset, raises misalign. It leaves ld_valid low, st_be zero and ld_data holding its previous value. Byte, left and right accesses never raise misalign.
- R13: Kind code 7 does nothing: ld_valid stays low, st_be is zero and misalign is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_kind | input | 3 | Access kind code (see R3 to R13) |
| req_addr_lo | input | 2 | Low address bits (byte offset in word) |
| mem_rdata | input | 32 | Word read from memory (loads) |
| reg_val | input | 32 | Old destination value (loads) or source value (stores) |
| ld_valid | output | 1 | Load result is to be written back |
| ld_data | output | 32 | Load result |
| st_be | output | 4 | Byte-lane write enables, bit 3 = lowest address |
| st_wdata | output | 32 | Lane-aligned store data |
| misalign | output | 1 | Misaligned halfword or word access |

## Verification
The assertions check the following on every cycle:
- Idle cycles produce no strobes.
- A fault never comes with a writeback or a lane enable.
- Left and right accesses never fault.
- Byte stores enable exactly one lane.
- Aligned word stores pass the register value through unchanged.
- Unsigned byte loads clear the upper bits.
- Stores and the unused kind code never produce a load writeback.

Only the bench's scenarios show the exact lane-merge results of the left and right forms at every offset, sign extension from particular byte values, and the retention of ld_data across a faulted load.

// File: rtl/be_align_pkg.sv
package be_align_pkg;

  // Access kind codes shared by loads and stores
  typedef enum logic [2:0] {
    ACC_BYTE_S = 3'd0,
    ACC_BYTE_U = 3'd1,
    ACC_HALF_S = 3'd2,
    ACC_HALF_U = 3'd3,
    ACC_WORD   = 3'd4,
    ACC_LEFT   = 3'd5,
    ACC_RIGHT  = 3'd6,
    ACC_NONE   = 3'd7
  } acc_kind_e;

  function automatic logic kind_is_half(acc_kind_e k);
    return (k == ACC_HALF_S) || (k == ACC_HALF_U);
  endfunction

  function automatic logic kind_is_byte(acc_kind_e k);
    return (k == ACC_BYTE_S) || (k == ACC_BYTE_U);
  endfunction

endpackage

// File: rtl/be_align_fault.sv
module be_align_fault
  import be_align_pkg::*;
#(
  parameter int LANES = 4
) (
  input  acc_kind_e                    kind,
  input  logic [$clog2(LANES)-1:0]     addr,
  output logic                         misaligned,
  output logic                         kind_ok
);

  always_comb begin
    misaligned = 1'b0;
    if (kind_is_half(kind)) begin
      misaligned = addr[0];
    end else if (kind == ACC_WORD) begin
      misaligned = |addr;
    end
  end

  assign kind_ok = (kind != ACC_NONE);

endmodule

// File: rtl/be_load_merge.sv
module be_load_merge
  import be_align_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  acc_kind_e                    kind,
  input  logic [$clog2(LANES)-1:0]     addr,
  input  logic [LANES*BYTE_W-1:0]      mem_word,
  input  logic [LANES*BYTE_W-1:0]      reg_word,
  output logic [LANES*BYTE_W-1:0]      ld_word
);

  localparam int DATA_W = LANES * BYTE_W;
  localparam int AW     = $clog2(LANES);

  // Lane 0 is the lowest address and the most significant byte
  logic [BYTE_W-1:0] mem_lane [LANES];
  logic [BYTE_W-1:0] reg_lane [LANES];
  logic [DATA_W-1:0] merged_word;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_split
    assign mem_lane[gi] = mem_word[DATA_W-1-gi*BYTE_W -: BYTE_W];
    assign reg_lane[gi] = reg_word[DATA_W-1-gi*BYTE_W -: BYTE_W];
  end

  // Word, left and right forms: per-lane choice between memory and register
  for (genvar gi = 0; gi < LANES; gi++) begin : g_merge
    logic [BYTE_W-1:0] lane_q;
    always_comb begin
      int src;
      lane_q = reg_lane[gi];
      src    = gi;
      case (kind)
        ACC_WORD: begin
          lane_q = mem_lane[gi];
        end
        ACC_LEFT: begin
          src = gi + int'(addr);
          if (src < LANES) lane_q = mem_lane[src[AW-1:0]];
        end
        ACC_RIGHT: begin
          src = gi - (LANES - 1 - int'(addr));
          if (src >= 0) lane_q = mem_lane[src[AW-1:0]];
        end
        default: lane_q = reg_lane[gi];
      endcase
    end
    assign merged_word[DATA_W-1-gi*BYTE_W -: BYTE_W] = lane_q;
  end

  // Byte and halfword extraction
  logic [BYTE_W-1:0] byte_v;
  logic [BYTE_W-1:0] half_hi;
  logic [BYTE_W-1:0] half_lo;

  assign byte_v  = mem_lane[addr];
  assign half_hi = mem_lane[{addr[AW-1:1], 1'b0}];
  assign half_lo = mem_lane[{addr[AW-1:1], 1'b1}];

  always_comb begin
    case (kind)
      ACC_BYTE_S: ld_word = {{(DATA_W-BYTE_W){byte_v[BYTE_W-1]}}, byte_v};
      ACC_BYTE_U: ld_word = {{(DATA_W-BYTE_W){1'b0}}, byte_v};
      ACC_HALF_S: ld_word = {{(DATA_W-2*BYTE_W){half_hi[BYTE_W-1]}}, half_hi, half_lo};
      ACC_HALF_U: ld_word = {{(DATA_W-2*BYTE_W){1'b0}}, half_hi, half_lo};
      default:    ld_word = merged_word;
    endcase
  end

endmodule

// File: rtl/be_store_shift.sv
module be_store_shift
  import be_align_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  acc_kind_e                    kind,
  input  logic [$clog2(LANES)-1:0]     addr,
  input  logic [LANES*BYTE_W-1:0]      reg_word,
  output logic [LANES-1:0]             be,
  output logic [LANES*BYTE_W-1:0]      wdata
);

  localparam int DATA_W = LANES * BYTE_W;
  localparam int AW     = $clog2(LANES);

  logic [BYTE_W-1:0] reg_lane [LANES];

  for (genvar gi = 0; gi < LANES; gi++) begin : g_split
    assign reg_lane[gi] = reg_word[DATA_W-1-gi*BYTE_W -: BYTE_W];
  end

  // Lane gj is memory offset gj; its enable sits at be[LANES-1-gj]
  for (genvar gj = 0; gj < LANES; gj++) begin : g_lane
    logic              en;
    logic [BYTE_W-1:0] lane_q;
    always_comb begin
      int src;
      en  = 1'b0;
      src = gj;
      case (kind)
        ACC_BYTE_S, ACC_BYTE_U: begin
          en  = (gj == int'(addr));
          src = LANES - 1;
        end
        ACC_HALF_S, ACC_HALF_U: begin
          en  = ((gj / 2) == (int'(addr) / 2));
          src = LANES - 2 + (gj % 2);
        end
        ACC_WORD: begin
          en  = 1'b1;
          src = gj;
        end
        ACC_LEFT: begin
          en  = (gj >= int'(addr));
          src = gj - int'(addr);
        end
        ACC_RIGHT: begin
          en  = (gj <= int'(addr));
          src = gj + LANES - 1 - int'(addr);
        end
        default: begin
          en  = 1'b0;
          src = gj;
        end
      endcase
      lane_q = en ? reg_lane[src[AW-1:0]] : '0;
    end
    assign be[LANES-1-gj]                          = en;
    assign wdata[DATA_W-1-gj*BYTE_W -: BYTE_W]     = lane_q;
  end

endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align
  import be_align_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic                         req_is_store,
  input  logic [2:0]                   req_kind,
  input  logic [$clog2(LANES)-1:0]     req_addr_lo,
  input  logic [LANES*BYTE_W-1:0]      mem_rdata,
  input  logic [LANES*BYTE_W-1:0]      reg_val,
  output logic                         ld_valid,
  output logic [LANES*BYTE_W-1:0]      ld_data,
  output logic [LANES-1:0]             st_be,
  output logic [LANES*BYTE_W-1:0]      st_wdata,
  output logic                         misalign
);

  localparam int DATA_W = LANES * BYTE_W;

  acc_kind_e          kind;
  logic               mis_w;
  logic               kind_ok_w;
  logic [DATA_W-1:0]  ld_w;
  logic [LANES-1:0]   be_w;
  logic [DATA_W-1:0]  wd_w;
  logic               do_load;
  logic               do_store;

  assign kind = acc_kind_e'(req_kind);

  be_align_fault #(.LANES(LANES)) u_fault (
    .kind       (kind),
    .addr       (req_addr_lo),
    .misaligned (mis_w),
    .kind_ok    (kind_ok_w)
  );

  be_load_merge #(.LANES(LANES), .BYTE_W(BYTE_W)) u_load (
    .kind     (kind),
    .addr     (req_addr_lo),
    .mem_word (mem_rdata),
    .reg_word (reg_val),
    .ld_word  (ld_w)
  );

  be_store_shift #(.LANES(LANES), .BYTE_W(BYTE_W)) u_store (
    .kind     (kind),
    .addr     (req_addr_lo),
    .reg_word (reg_val),
    .be       (be_w),
    .wdata    (wd_w)
  );

  assign do_load  = req_valid && !req_is_store && kind_ok_w && !mis_w;
  assign do_store = req_valid &&  req_is_store && kind_ok_w && !mis_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
      st_be    <= '0;
      st_wdata <= '0;
      misalign <= 1'b0;
    end else begin
      ld_valid <= do_load;
      misalign <= req_valid && mis_w;
      st_be    <= do_store ? be_w : '0;
      if (do_load)  ld_data  <= ld_w;
      if (do_store) st_wdata <= wd_w;
    end
  end

endmodule

// File: rtl/be_lsu_align_chk.sv
module be_lsu_align_chk #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic                         req_is_store,
  input  logic [2:0]                   req_kind,
  input  logic [$clog2(LANES)-1:0]     req_addr_lo,
  input  logic [LANES*BYTE_W-1:0]      reg_val,
  input  logic                         ld_valid,
  input  logic [LANES*BYTE_W-1:0]      ld_data,
  input  logic [LANES-1:0]             st_be,
  input  logic [LANES*BYTE_W-1:0]      st_wdata,
  input  logic                         misalign
);

  localparam int DATA_W = LANES * BYTE_W;

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!ld_valid && st_be == '0 && !misalign));

  assert_fault_blocks_R12: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (!ld_valid && st_be == '0));

  assert_partial_no_fault_R12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_kind == 3'd5 || req_kind == 3'd6)) |=> !misalign);

  assert_byte_one_lane_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_store && req_kind <= 3'd1) |=> ($countones(st_be) == 1));

  assert_word_store_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_store && req_kind == 3'd4 && req_addr_lo == '0)
      |=> (st_be == '1 && st_wdata == $past(reg_val)));

  assert_ubyte_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_store && req_kind == 3'd1)
      |=> (ld_valid && ld_data[DATA_W-1:BYTE_W] == '0));

  assert_none_kind_R13: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd7) |=> (!ld_valid && st_be == '0 && !misalign));

  assert_store_no_wb_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_store) |=> !ld_valid);

endmodule

bind be_lsu_align be_lsu_align_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_is_store (req_is_store),
  .req_kind     (req_kind),
  .req_addr_lo  (req_addr_lo),
  .reg_val      (reg_val),
  .ld_valid     (ld_valid),
  .ld_data      (ld_data),
  .st_be        (st_be),
  .st_wdata     (st_wdata),
  .misalign     (misalign)
);

// File: tb/be_lsu_align_tb.sv
module be_lsu_align_tb;

  localparam logic [31:0] MW  = 32'h8192A3B4;
  localparam logic [31:0] MP  = 32'h1A2B3C4D;
  localparam logic [31:0] RV  = 32'h11223344;

  typedef struct packed {
    logic        st;
    logic [2:0]  kind;
    logic [1:0]  a;
    logic [31:0] mem;
    logic        vld;
    logic        flt;
    logic [3:0]  be;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t vl(int k, int a, logic [31:0] m, logic [31:0] e, int r);
    return '{1'b0, 3'(k), 2'(a), m, 1'b1, 1'b0, 4'h0, e, 4'(r)};
  endfunction
  function automatic vec_t vs(int k, int a, logic [3:0] b, logic [31:0] w, int r);
    return '{1'b1, 3'(k), 2'(a), 32'h0, 1'b0, 1'b0, b, w, 4'(r)};
  endfunction
  function automatic vec_t vf(logic s, int k, int a, int r);
    return '{s, 3'(k), 2'(a), MW, 1'b0, 1'b1, 4'h0, 32'h0, 4'(r)};
  endfunction
  function automatic vec_t vn(logic s, int r);
    return '{s, 3'd7, 2'd0, MW, 1'b0, 1'b0, 4'h0, 32'h0, 4'(r)};
  endfunction

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    vl(0, 0, MW, 32'hFFFFFF81, 3),   // R3 signed byte, offset 0
    vl(1, 0, MW, 32'h00000081, 3),   // R3 unsigned byte
    vl(0, 3, MW, 32'hFFFFFFB4, 3),   // R3 lane order, offset 3
    vl(1, 1, MW, 32'h00000092, 3),   // R3
    vl(0, 2, MP, 32'h0000003C, 3),   // R3 positive byte
    vl(2, 0, MW, 32'hFFFF8192, 4),   // R4 signed half
    vl(3, 2, MW, 32'h0000A3B4, 4),   // R4 unsigned half
    vl(2, 2, MP, 32'h00003C4D, 4),   // R4 positive half
    vl(4, 0, MW, 32'h8192A3B4, 5),   // R5 word
    vl(5, 0, MW, 32'h8192A3B4, 6),   // R6 left load
    vl(5, 1, MW, 32'h92A3B444, 6),   // R6
    vl(5, 2, MW, 32'hA3B43344, 6),   // R6
    vl(5, 3, MW, 32'hB4223344, 6),   // R6
    vl(6, 0, MW, 32'h11223381, 7),   // R7 right load
    vl(6, 1, MW, 32'h11228192, 7),   // R7
    vl(6, 2, MW, 32'h118192A3, 7),   // R7
    vl(6, 3, MW, 32'h8192A3B4, 7),   // R7
    vs(0, 0, 4'b1000, 32'h44000000, 8),  // R8 byte store
    vs(0, 3, 4'b0001, 32'h00000044, 8),  // R8
    vs(0, 1, 4'b0100, 32'h00440000, 8),  // R8
    vs(1, 2, 4'b0010, 32'h00004400, 8),  // R8 code 1 as byte store
    vs(2, 0, 4'b1100, 32'h33440000, 8),  // R8 half store
    vs(3, 2, 4'b0011, 32'h00003344, 8),  // R8
    vs(4, 0, 4'b1111, 32'h11223344, 9),  // R9 word store
    vs(5, 0, 4'b1111, 32'h11223344, 10), // R10 left store
    vs(5, 1, 4'b0111, 32'h00112233, 10), // R10
    vs(5, 2, 4'b0011, 32'h00001122, 10), // R10
    vs(5, 3, 4'b0001, 32'h00000011, 10), // R10
    vs(6, 0, 4'b1000, 32'h44000000, 11), // R11 right store
    vs(6, 1, 4'b1100, 32'h33440000, 11), // R11
    vs(6, 2, 4'b1110, 32'h22334400, 11), // R11
    vs(6, 3, 4'b1111, 32'h11223344, 11), // R11
    vf(1'b0, 2, 1, 12),  // R12 odd half load
    vf(1'b1, 4, 2, 12),  // R12 word store offset 2
    vf(1'b0, 4, 3, 12),  // R12 word load offset 3
    vf(1'b1, 3, 3, 12),  // R12 half store offset 3
    vn(1'b0, 13),        // R13 unused code, load
    vn(1'b1, 13)         // R13 unused code, store
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_is_store = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [1:0]  req_addr_lo = 2'd0;
  logic [31:0] mem_rdata = 32'h0;
  logic [31:0] reg_val = 32'h0;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic [3:0]  st_be;
  logic [31:0] st_wdata;
  logic        misalign;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  be_lsu_align u_dut (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_is_store (req_is_store),
    .req_kind     (req_kind),
    .req_addr_lo  (req_addr_lo),
    .mem_rdata    (mem_rdata),
    .reg_val      (reg_val),
    .ld_valid     (ld_valid),
    .ld_data      (ld_data),
    .st_be        (st_be),
    .st_wdata     (st_wdata),
    .misalign     (misalign)
  );

  task automatic chk(input int r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %08h expected %08h", r, what, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [2:0] k, input logic [1:0] a,
                       input logic [31:0] m, input logic [31:0] rv);
    req_valid    = 1'b1;
    req_is_store = s;
    req_kind     = k;
    req_addr_lo  = a;
    mem_rdata    = m;
    reg_val      = rv;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(1, "reset ld_valid", 32'(ld_valid), 32'h0);
    chk(1, "reset ld_data", ld_data, 32'h0);
    chk(1, "reset st_be", 32'(st_be), 32'h0);
    chk(1, "reset st_wdata", st_wdata, 32'h0);
    chk(1, "reset misalign", 32'(misalign), 32'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].st, VEC[i].kind, VEC[i].a, VEC[i].mem, RV);
      @(negedge clk);
      chk(int'(VEC[i].req), "ld_valid", 32'(ld_valid), 32'(VEC[i].vld));
      chk(int'(VEC[i].req), "misalign", 32'(misalign), 32'(VEC[i].flt));
      chk(int'(VEC[i].req), "st_be", 32'(st_be), 32'(VEC[i].be));
      if (VEC[i].vld) chk(int'(VEC[i].req), "ld_data", ld_data, VEC[i].d);
      if (VEC[i].st && VEC[i].be != 4'h0) chk(int'(VEC[i].req), "st_wdata", st_wdata, VEC[i].d);
    end

    // R2: idle cycle gives no strobes
    req_valid = 1'b0;
    @(negedge clk);
    chk(2, "idle ld_valid", 32'(ld_valid), 32'h0);
    chk(2, "idle st_be", 32'(st_be), 32'h0);
    chk(2, "idle misalign", 32'(misalign), 32'h0);

    // R12: faulted load keeps previous ld_data
    drive(1'b0, 3'd4, 2'd0, MW, RV);
    @(negedge clk);
    chk(5, "word load before fault", ld_data, MW);
    drive(1'b0, 3'd2, 2'd3, 32'hDEADBEEF, RV);
    @(negedge clk);
    chk(12, "fault ld_valid", 32'(ld_valid), 32'h0);
    chk(12, "fault misalign", 32'(misalign), 32'h1);
    chk(12, "fault keeps ld_data", ld_data, MW);

    // R12: byte access at odd offset never faults
    drive(1'b1, 3'd0, 2'd3, 32'h0, 32'hCAFEF00D);
    @(negedge clk);
    chk(12, "odd byte store no fault", 32'(misalign), 32'h0);
    chk(8, "odd byte store lane", st_wdata, 32'h0000000D);

    // R1: reset wins over a pending request
    drive(1'b0, 3'd4, 2'd0, 32'h55AA55AA, RV);
    rst = 1'b1;
    @(negedge clk);
    chk(1, "reset over request ld_valid", 32'(ld_valid), 32'h0);
    chk(1, "reset over request ld_data", ld_data, 32'h0);
    chk(1, "reset over request st_wdata", st_wdata, 32'h0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule